// File: doc/BRIEF.md
# Path Trace String Buffer

This block holds, for every low-order path channel, two 16-byte trace strings: the string to send and the string the receiver expects to see. A microprocessor reaches both through a small register window. Each channel has one data register per direction and one configuration register. No address register exists for the string bytes. Instead, a single byte pointer shared by every channel and both directions steps on each data access. A write of any value to a global register returns that pointer to byte 0.

On the transmit side, each channel sends its stored string one byte per multiframe tick. While the processor holds write access to a channel's transmit string, the outgoing byte is replaced by an unequipped code. The code is 00H or 01H, chosen by a global mode bit. A per-channel bit raises a forced alarm-indication request toward the network.

The register address splits into a channel field (upper four bits) and a register select field (lower four bits). Channel field 0 is the global space. Channels 1 to `NUM_CH` (at most 15) carry the per-channel registers.

Top module: `trace_buf`

## Requirements
- R1: After reset, the pointer is 0 and all string bytes are 00H. Each configuration register reads 40H (access enabled, force clear). The mode bit is 0. `rdata` is 00H, every `tx_trace` byte is 00H and every `tx_ais` bit is 0.
- R2: A read or write of the expected-string register (select 2H) or of the transmit-string register (select 3H) on a mapped channel acts on the byte at the pointer. The pointer then steps by one, wrapping from 15 to 0.
- R3: A write of any data to global address 04H sets the pointer to 0. A read of 04H returns 00H and leaves the pointer unchanged.
- R4: The same pointer serves every channel and both directions. An access to one channel's string moves the byte position used by the next access to any other channel or direction.
- R5: A write to the transmit-string register while that channel's access bit is 0 leaves the stored byte unchanged, but the pointer still steps. Writes to the expected-string register always take effect.
- R6: While a channel's access bit (configuration register select 9H, bit 6) is 1, its `tx_trace` byte is 00H when the global mode bit (address 08H, bit 0) is 0 and 01H when it is 1.
- R7: While the access bit is 0, each cycle with that channel's `mf_tick` high loads transmit byte 0, 1, … 15, 0, … in turn. The loaded byte appears on `tx_trace` from the following cycle. The sequence index and the shown byte return to 0 while access is enabled, so after a disable `tx_trace` shows 00H until the first tick.
- R8: `tx_ais` for a channel equals bit 5 of its configuration register. The configuration register keeps only bits 6 and 5; all other bits read as 0.
- R9: If a read strobe and a write strobe are both asserted in the same cycle, only the write is performed. `rdata` keeps its previous value and the pointer steps once.
- R10: `rdata` is loaded on the clock edge that samples a read strobe and holds until the next read. Reads of unmapped addresses return 00H. Accesses to channels above `NUM_CH` change no state and do not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address: channel field [7:4], select field [3:0] |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| mf_tick | input | NUM_CH | Per-channel multiframe tick, bit i for channel i+1 |
| tx_trace | output | 8*NUM_CH | Outgoing trace byte, bits [8i+7:8i] for channel i+1 |
| tx_ais | output | NUM_CH | Forced alarm-indication request per channel |

## Verification
The bench mixes random data and configuration traffic across channels with directed cases. A design that gave each channel its own pointer, or kept separate pointers per direction, returns wrong bytes once accesses interleave. Transmit writes with access disabled are read back later. A design that drops the access gate corrupts the stored string, and one that also freezes the pointer shifts every later byte. Same-cycle read and write strobes, pointer wrap across 15, the reset register hit with non-zero data, and the transmit sequence running past byte 15 each target a design that double-steps, wraps wrongly, or starts the string mid-way after access is released.

// File: rtl/trace_pkg.sv
package trace_pkg;

    localparam int STR_LEN  = 16;
    localparam int PTR_W    = $clog2(STR_LEN);
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int SEL_W    = 4;
    localparam int CH_W     = ADDR_W - SEL_W;

    localparam logic [SEL_W-1:0] SEL_PRST = 4'h4;
    localparam logic [SEL_W-1:0] SEL_MODE = 4'h8;
    localparam logic [SEL_W-1:0] SEL_EXP  = 4'h2;
    localparam logic [SEL_W-1:0] SEL_TX   = 4'h3;
    localparam logic [SEL_W-1:0] SEL_CFG  = 4'h9;

    localparam int CFG_ACC_BIT = 6;
    localparam int CFG_AIS_BIT = 5;

    localparam logic [BYTE_W-1:0] UNEQ_STD = 8'h00;
    localparam logic [BYTE_W-1:0] UNEQ_SUP = 8'h01;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PRST,
        RK_MODE,
        RK_EXP,
        RK_TX,
        RK_CFG
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [CH_W-1:0]  ch;
    } reg_hit_t;

    typedef struct packed {
        logic acc_en;
        logic ais_frc;
    } chan_cfg_t;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(STR_LEN - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [BYTE_W-1:0] unequip_code(input logic sup);
        return sup ? UNEQ_SUP : UNEQ_STD;
    endfunction

    function automatic logic [BYTE_W-1:0] cfg_to_byte(input chan_cfg_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[CFG_ACC_BIT] = c.acc_en;
        b[CFG_AIS_BIT] = c.ais_frc;
        return b;
    endfunction

endpackage

// File: rtl/trace_decode.sv
module trace_decode
    import trace_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_hit_t          hit
);
    logic [CH_W-1:0]  ch_f;
    logic [SEL_W-1:0] sel_f;

    assign ch_f  = addr[ADDR_W-1:SEL_W];
    assign sel_f = addr[SEL_W-1:0];

    always_comb begin
        hit.kind = RK_NONE;
        hit.ch   = ch_f;
        if (ch_f == '0) begin
            if (sel_f == SEL_PRST)      hit.kind = RK_PRST;
            else if (sel_f == SEL_MODE) hit.kind = RK_MODE;
        end else if (int'(ch_f) <= NUM_CH) begin
            if (sel_f == SEL_EXP)       hit.kind = RK_EXP;
            else if (sel_f == SEL_TX)   hit.kind = RK_TX;
            else if (sel_f == SEL_CFG)  hit.kind = RK_CFG;
        end
    end

endmodule

// File: rtl/trace_ptr.sv
module trace_ptr
    import trace_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic             clr,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (clr) ptr <= '0;
        else if (adv) ptr <= ptr_step(ptr);
    end

    assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr == '0));

    assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && ptr == PTR_W'(STR_LEN - 1)) |=> (ptr == '0));

    assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!adv && !clr) |=> $stable(ptr));

endmodule

// File: rtl/trace_chan.sv
module trace_chan
    import trace_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_exp,
    input  logic              wr_tx,
    input  logic              wr_cfg,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              sup_mode,
    input  logic              mf_tick,
    output logic [BYTE_W-1:0] exp_rd,
    output logic [BYTE_W-1:0] tx_rd,
    output logic [BYTE_W-1:0] cfg_rd,
    output logic [BYTE_W-1:0] tx_trace,
    output logic              tx_ais
);
    logic [STR_LEN-1:0][BYTE_W-1:0] exp_mem;
    logic [STR_LEN-1:0][BYTE_W-1:0] tx_mem;
    chan_cfg_t                      cfg;
    logic [PTR_W-1:0]               tx_idx;
    logic [BYTE_W-1:0]              tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_mem <= '0;
        end else if (wr_exp) begin
            exp_mem[ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_mem <= '0;
        end else if (wr_tx && cfg.acc_en) begin
            tx_mem[ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.acc_en  <= 1'b1;
            cfg.ais_frc <= 1'b0;
        end else if (wr_cfg) begin
            cfg.acc_en  <= wdata[CFG_ACC_BIT];
            cfg.ais_frc <= wdata[CFG_AIS_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_idx <= '0;
            tx_q   <= '0;
        end else if (cfg.acc_en) begin
            tx_idx <= '0;
            tx_q   <= '0;
        end else if (mf_tick) begin
            tx_q   <= tx_mem[tx_idx];
            tx_idx <= ptr_step(tx_idx);
        end
    end

    assign exp_rd   = exp_mem[ptr];
    assign tx_rd    = tx_mem[ptr];
    assign cfg_rd   = cfg_to_byte(cfg);
    assign tx_trace = cfg.acc_en ? unequip_code(sup_mode) : tx_q;
    assign tx_ais   = cfg.ais_frc;

    assert_tx_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && !cfg.acc_en) |=> $stable(tx_mem));

    assert_exp_written_R5: assert property (@(posedge clk) disable iff (rst)
        wr_exp |=> (exp_mem[$past(ptr)] == $past(wdata)));

    assert_override_code_R6: assert property (@(posedge clk) disable iff (rst)
        cfg.acc_en |-> (tx_trace == UNEQ_STD || tx_trace == UNEQ_SUP));

    assert_seq_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!cfg.acc_en && !mf_tick && !wr_cfg) |=> ($stable(tx_q) && $stable(tx_idx)));

endmodule

// File: rtl/trace_buf.sv
module trace_buf
    import trace_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        rdata,
    input  logic [NUM_CH-1:0]        mf_tick,
    output logic [NUM_CH*BYTE_W-1:0] tx_trace,
    output logic [NUM_CH-1:0]        tx_ais
);
    reg_hit_t          hit;
    logic [PTR_W-1:0]  ptr;
    logic              ptr_adv;
    logic              ptr_clr;
    logic              sup_mode;
    logic [BYTE_W-1:0] rd_byte;
    logic              is_data;

    logic [BYTE_W-1:0] exp_rd [NUM_CH];
    logic [BYTE_W-1:0] tx_rd  [NUM_CH];
    logic [BYTE_W-1:0] cfg_rd [NUM_CH];

    trace_decode #(.NUM_CH(NUM_CH)) u_decode (
        .addr (addr),
        .hit  (hit)
    );

    assign is_data = (hit.kind == RK_EXP) || (hit.kind == RK_TX);
    assign ptr_adv = (wr_en || rd_en) && is_data;
    assign ptr_clr = wr_en && (hit.kind == RK_PRST);

    trace_ptr u_ptr (
        .clk (clk),
        .rst (rst),
        .adv (ptr_adv),
        .clr (ptr_clr),
        .ptr (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst)                                sup_mode <= 1'b0;
        else if (wr_en && hit.kind == RK_MODE)  sup_mode <= wdata[0];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic mine;
        assign mine = (hit.ch == CH_W'(g + 1));

        trace_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_exp   (wr_en && mine && hit.kind == RK_EXP),
            .wr_tx    (wr_en && mine && hit.kind == RK_TX),
            .wr_cfg   (wr_en && mine && hit.kind == RK_CFG),
            .wdata    (wdata),
            .ptr      (ptr),
            .sup_mode (sup_mode),
            .mf_tick  (mf_tick[g]),
            .exp_rd   (exp_rd[g]),
            .tx_rd    (tx_rd[g]),
            .cfg_rd   (cfg_rd[g]),
            .tx_trace (tx_trace[g*BYTE_W +: BYTE_W]),
            .tx_ais   (tx_ais[g])
        );
    end

    always_comb begin
        rd_byte = '0;
        if (hit.kind == RK_MODE) begin
            rd_byte = {{(BYTE_W-1){1'b0}}, sup_mode};
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit.ch == CH_W'(i + 1)) begin
                case (hit.kind)
                    RK_EXP:  rd_byte = exp_rd[i];
                    RK_TX:   rd_byte = tx_rd[i];
                    RK_CFG:  rd_byte = cfg_rd[i];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  rdata <= '0;
        else if (rd_en && !wr_en) rdata <= rd_byte;
    end

    assert_rw_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |=> $stable(rdata));

    assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_en) && hit.kind == RK_NONE) |=> $stable(ptr));

endmodule

// File: tb/test_trace_buf.sv
module test_trace_buf;

    localparam int NCH = 8;
    localparam int LEN = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [7:0]       addr;
    logic             wr_en;
    logic             rd_en;
    logic [7:0]       wdata;
    logic [7:0]       rdata;
    logic [NCH-1:0]   mf_tick;
    logic [NCH*8-1:0] tx_trace;
    logic [NCH-1:0]   tx_ais;

    trace_buf #(.NUM_CH(NCH)) i_trace_buf (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .mf_tick  (mf_tick),
        .tx_trace (tx_trace),
        .tx_ais   (tx_ais)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [7:0] m_exp [1:NCH][LEN];
    logic [7:0] m_tx  [1:NCH][LEN];
    logic [7:0] m_cfg [1:NCH];
    logic       m_sup;
    int         m_ptr;
    logic [7:0] m_rdata;

    function automatic logic [7:0] a_of(input int ch, input logic [3:0] sel);
        return {4'(ch), sel};
    endfunction

    function automatic logic [7:0] code_of(input logic sup);
        return sup ? 8'h01 : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic bus_rw(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic step_ptr();
        m_ptr = (m_ptr + 1) % LEN;
    endtask

    // data-register write with model update
    task automatic data_wr(input int ch, input bit tx, input logic [7:0] d);
        bus_wr(a_of(ch, tx ? 4'h3 : 4'h2), d);
        if (tx) begin
            if (m_cfg[ch][6]) m_tx[ch][m_ptr] = d;
        end else begin
            m_exp[ch][m_ptr] = d;
        end
        step_ptr();
    endtask

    task automatic data_rd(input int ch, input bit tx, input string tag);
        logic [7:0] got;
        logic [7:0] want;
        want = tx ? m_tx[ch][m_ptr] : m_exp[ch][m_ptr];
        bus_rd(a_of(ch, tx ? 4'h3 : 4'h2), got);
        chk(tag, got, want);
        m_rdata = want;
        step_ptr();
    endtask

    task automatic cfg_wr(input int ch, input logic [7:0] d);
        bus_wr(a_of(ch, 4'h9), d);
        m_cfg[ch] = d & 8'h60;
    endtask

    task automatic ptr_reset(input logic [7:0] d);
        bus_wr(8'h04, d);
        m_ptr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; addr = '0; wr_en = 0; rd_en = 0; wdata = '0; mf_tick = '0;
        for (int c = 1; c <= NCH; c++) begin
            m_cfg[c] = 8'h40;
            for (int b = 0; b < LEN; b++) begin
                m_exp[c][b] = 8'h00;
                m_tx[c][b]  = 8'h00;
            end
        end
        m_sup = 0; m_ptr = 0; m_rdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state at the ports
        chk("R1 rdata after reset", rdata, 8'h00);
        chk("R1 tx_trace after reset", tx_trace, '0);
        chk("R1 tx_ais after reset", tx_ais, '0);
        bus_rd(a_of(1, 4'h9), got);
        chk("R1 config reset value", got, 8'h40);
        bus_rd(8'h08, got);
        chk("R1 mode reset value", got, 8'h00);
        data_rd(NCH, 1'b0, "R1 expected byte 0 after reset");

        // R2/R3: fill strings, pointer reset with non-zero data, read back
        ptr_reset(8'hA5);
        for (int b = 0; b < LEN; b++) data_wr(1, 1'b1, 8'(8'h30 + b));
        for (int b = 0; b < LEN; b++) data_wr(2, 1'b0, 8'(8'hC0 ^ b));
        chk("R2 pointer wrapped to 0 after 32 accesses", 32'(m_ptr), 32'd0);
        data_rd(1, 1'b1, "R2 byte 0 after wrap");
        ptr_reset(8'hFF);
        for (int b = 0; b < LEN; b++) data_rd(2, 1'b0, "R3 expected string after pointer reset");
        bus_rd(8'h04, got);
        chk("R3 read of reset register", got, 8'h00);
        data_rd(1, 1'b1, "R3 read of 04H leaves pointer");

        // R4: shared pointer across channels and directions
        ptr_reset(8'h00);
        data_rd(2, 1'b0, "R4 ch2 expected byte 0");
        data_rd(1, 1'b1, "R4 ch1 transmit byte 1 after ch2 access");
        data_wr(3, 1'b0, 8'h77);
        data_rd(1, 1'b1, "R4 ch1 transmit byte 3");

        // R9: simultaneous strobes on a data register
        bus_rw(a_of(4, 4'h2), 8'h9C);
        m_exp[4][m_ptr] = 8'h9C;
        step_ptr();
        chk("R9 rdata kept on read+write", rdata, m_rdata);
        m_ptr = (m_ptr + LEN - 1) % LEN;
        ptr_reset(8'h00);
        for (int b = 0; b < 4; b++) step_ptr();
        bus_wr(8'h04, 8'h00);
        m_ptr = 0;
        for (int b = 0; b < 4; b++) data_rd(4, 1'b0, "R9 single pointer step, write applied");
        data_rd(4, 1'b0, "R9 byte after simultaneous write");

        // R10: unmapped channel and select
        ptr_reset(8'h00);
        bus_wr(a_of(NCH + 1, 4'h2), 8'h11);
        bus_rd(a_of(NCH + 1, 4'h3), got);
        chk("R10 unmapped read returns 00", got, 8'h00);
        bus_rd(a_of(1, 4'hE), got);
        chk("R10 unmapped select returns 00", got, 8'h00);
        m_rdata = 8'h00;
        data_rd(1, 1'b1, "R10 pointer unmoved by unmapped access");

        // R5: transmit write ignored while access disabled
        cfg_wr(5, 8'h00);
        ptr_reset(8'h00);
        data_wr(5, 1'b1, 8'hEE);
        data_wr(5, 1'b0, 8'h5A);
        ptr_reset(8'h00);
        data_rd(5, 1'b1, "R5 locked transmit byte unchanged");
        data_rd(5, 1'b0, "R5 expected write always applied");

        // R6 / R8: override code and force bit
        bus_rd(a_of(5, 4'h9), got);
        chk("R8 config readback with access off", got, 8'h00);
        cfg_wr(5, 8'h40);
        chk("R6 standard unequipped code", tx_trace[4*8 +: 8], 8'h00);
        bus_wr(8'h08, 8'h01); m_sup = 1;
        chk("R6 supervisory unequipped code", tx_trace[4*8 +: 8], 8'h01);
        cfg_wr(5, 8'hFF);
        chk("R8 force bit drives tx_ais", tx_ais, 8'h10);
        bus_rd(a_of(5, 4'h9), got);
        chk("R8 config keeps only bits 6 and 5", got, 8'h60);
        cfg_wr(5, 8'h40);
        chk("R8 force cleared", tx_ais, 8'h00);

        // R7: transmit sequence on channel 1
        cfg_wr(1, 8'h00);
        chk("R7 shown byte 00 before first tick", tx_trace[7:0], 8'h00);
        for (int t = 0; t < LEN + 3; t++) begin
            @(negedge clk); mf_tick[0] = 1'b1;
            @(negedge clk); mf_tick[0] = 1'b0;
            chk("R7 transmit sequence byte", tx_trace[7:0], m_tx[1][t % LEN]);
            @(negedge clk);
            chk("R7 byte held between ticks", tx_trace[7:0], m_tx[1][t % LEN]);
        end
        cfg_wr(1, 8'h40);
        chk("R6 override after re-enable", tx_trace[7:0], code_of(m_sup));
        cfg_wr(1, 8'h00);
        @(negedge clk); mf_tick[0] = 1'b1;
        @(negedge clk); mf_tick[0] = 1'b0;
        chk("R7 sequence restarts at byte 0", tx_trace[7:0], m_tx[1][0]);
        cfg_wr(1, 8'h40);

        // random traffic across channels and directions
        ptr_reset(8'h00);
        for (int n = 0; n < 600; n++) begin
            int c;
            int r;
            c = 1 + $urandom_range(NCH - 1);
            r = $urandom_range(11);
            case (r)
                0, 1:    data_wr(c, 1'b0, 8'($urandom));
                2, 3:    data_wr(c, 1'b1, 8'($urandom));
                4, 5:    data_rd(c, 1'b0, "R2 random expected read");
                6, 7:    data_rd(c, 1'b1, "R5 random transmit read");
                8:       cfg_wr(c, 8'($urandom));
                9:       ptr_reset(8'($urandom));
                10: begin
                    bus_rw(a_of(c, 4'h2), 8'h3C);
                    m_exp[c][m_ptr] = 8'h3C;
                    step_ptr();
                    chk("R9 random read+write keeps rdata", rdata, m_rdata);
                end
                default: begin
                    bus_rd(a_of(c, 4'h9), got);
                    chk("R8 random config read", got, m_cfg[c]);
                    m_rdata = m_cfg[c];
                end
            endcase
        end
        for (int c = 1; c <= NCH; c++) begin
            chk("R8 tx_ais matches force bits", 32'(tx_ais[c-1]), 32'(m_cfg[c][5]));
            if (m_cfg[c][6])
                chk("R6 override after random traffic", tx_trace[(c-1)*8 +: 8], code_of(m_sup));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule